// File: doc/BRIEF.md
# Line-Qualified NRZ Signature Detector

This block recognises a short identification code that a broadcaster places on one line of each video field. The luminance of that line is sliced into bits against a programmable separation level. An NRZ sampling clock marks where each code bit sits. The block counts lines from field and line start pulses. On the designated line it takes one sample per rising edge of the sampling clock, each sample delayed by a programmable number of system clock cycles. When the line ends it compares the captured bits with a fixed five-bit signature.

The result is one identification flag. It changes at most once per field and keeps its value until the next evaluation. The flag is meant to drive a display-format decision further down the chip.

All inputs are synchronous to `clk`. The sampling clock input is treated as a level, and its rising edge is found by comparing it with its value in the previous cycle. The signature defaults to 1,0,1,1,0 in order of arrival, and the designated line defaults to 22. Both are parameters.

Top module: `edtv_detect`

## Requirements
- R1: A sample bit is 1 when `luma` is greater than or equal to `sep_level` and 0 when `luma` is below it. Equality counts as 1.
- R2: A rising edge of `nrz_clk` is a cycle where `nrz_clk` is 1 and was 0 in the previous cycle. The sample for that edge is taken `delay_cfg` cycles after the edge cycle. A value of 0 means the sample is taken in the edge cycle itself.
- R3: Only one delayed sample can be outstanding at a time. A new edge that arrives while a sample is pending restarts the delay from that new edge, and the earlier pending sample is dropped.
- R4: Lines are counted as follows. A `field_start` pulse makes the current line 1. A `line_start` pulse without `field_start` advances the line by one. `field_start` wins when both arrive together. A sample counts only if the current line equals the target line (22) at the cycle the sample is taken.
- R5: Only the first five samples on the target line are kept. Further samples on that line have no effect.
- R6: The target line ends on a cycle where the current line is 22 and `line_start` or `field_start` is 1. In the following cycle `edtv_id` becomes 1 if exactly five samples were kept and, first to last, they read 1,0,1,1,0. Otherwise `edtv_id` becomes 0. A sample that falls in the ending cycle itself is not kept.
- R7: If the target line ends with fewer than five kept samples, `edtv_id` becomes 0.
- R8: `edtv_id` is 0 after reset and changes only in the cycle after the target line ends. Between evaluations it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nrz_clk | input | 1 | NRZ sampling clock, as a synchronous level |
| luma | input | LUMA_W (8) | Digitised luminance |
| sep_level | input | LUMA_W (8) | Slicing threshold |
| delay_cfg | input | DLY_W (4) | Cycles from a sampling-clock edge to its sample |
| field_start | input | 1 | One-cycle pulse at the start of a field |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| edtv_id | output | 1 | Signature-detected flag |

## Verification
Because the flag is updated only once per field, any wrong internal state stays hidden until the next end of line 22. It then shows up as one wrong flag value that lasts a whole field.

- A line counter that is off by one moves the sampling window. This shows up as a missed match, or as a false match when the code is placed on line 21.
- A delay counter or edge detector that is off by a cycle shifts every sample by one cycle. Near a threshold or bit boundary this flips bits.
- A kept-sample counter that keeps too many or too few samples changes the result of the extra-edge and short-line fields.

A per-cycle reference comparison catches any wrong flag on the first cycle after that line ends.

// File: rtl/edtv_pkg.sv
package edtv_pkg;
    localparam int LUMA_W_DEF   = 8;
    localparam int DLY_W_DEF    = 4;
    localparam int LINE_W_DEF   = 10;
    localparam int PAT_LEN_DEF  = 5;
    localparam int TARGET_DEF   = 22;
    // first received bit is the MSB
    localparam logic [PAT_LEN_DEF-1:0] SIGNATURE_DEF = 5'b10110;
endpackage

// File: rtl/nrz_strobe_gen.sv
module nrz_strobe_gen #(
    parameter int DLY_W = edtv_pkg::DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nrz_clk,
    input  logic [DLY_W-1:0] delay_cfg,
    output logic             edge_o,
    output logic             strobe_o
);
    typedef struct packed {
        logic             prev;
        logic             pend;
        logic [DLY_W-1:0] cnt;
    } strobe_st_t;

    strobe_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        edge_o   = nrz_clk & ~s_q.prev;
        strobe_o = (edge_o && (delay_cfg == '0)) || (s_q.pend && (s_q.cnt == '0));
        s_d.prev = nrz_clk;
        if (edge_o) begin
            // a fresh edge restarts any pending delay
            s_d.pend = (delay_cfg != '0);
            s_d.cnt  = delay_cfg - DLY_W'(1);
        end else if (s_q.pend) begin
            if (s_q.cnt == '0) begin
                s_d.pend = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - DLY_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/line_tracker.sv
module line_tracker #(
    parameter int LINE_W      = edtv_pkg::LINE_W_DEF,
    parameter int TARGET_LINE = edtv_pkg::TARGET_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_start,
    output logic [LINE_W-1:0] line_o,
    output logic              on_target_o,
    output logic              end_o
);
    localparam logic [LINE_W-1:0] TARGET_V = LINE_W'(TARGET_LINE);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
    } line_st_t;

    line_st_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        line_o      = s_q.line;
        on_target_o = (s_q.line == TARGET_V);
        end_o       = on_target_o && (field_start || line_start);
        if (field_start) begin
            s_d.line = LINE_W'(1);
        end else if (line_start && (s_q.line != LINE_MAX)) begin
            s_d.line = s_q.line + LINE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pattern_sampler.sv
module pattern_sampler #(
    parameter int                 LUMA_W    = edtv_pkg::LUMA_W_DEF,
    parameter int                 PAT_LEN   = edtv_pkg::PAT_LEN_DEF,
    parameter logic [PAT_LEN-1:0] SIGNATURE = edtv_pkg::SIGNATURE_DEF,
    localparam int                CNT_W     = $clog2(PAT_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              on_target,
    input  logic              end_line,
    input  logic [LUMA_W-1:0] luma,
    input  logic [LUMA_W-1:0] sep_level,
    output logic [CNT_W-1:0]  count_o,
    output logic              id_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(PAT_LEN);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [PAT_LEN-1:0] bits;
        logic               id;
    } samp_st_t;

    samp_st_t s_d, s_q;
    logic     slice;
    logic     take;

    always_comb begin
        s_d     = s_q;
        slice   = (luma >= sep_level);
        take    = strobe && on_target && (s_q.cnt < FULL);
        count_o = s_q.cnt;
        id_o    = s_q.id;
        if (end_line) begin
            s_d.id   = (s_q.cnt == FULL) && (s_q.bits == SIGNATURE);
            s_d.cnt  = '0;
            s_d.bits = '0;
        end else if (take) begin
            s_d.bits = {s_q.bits[PAT_LEN-2:0], slice};
            s_d.cnt  = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/edtv_detect.sv
module edtv_detect #(
    parameter int                 LUMA_W      = edtv_pkg::LUMA_W_DEF,
    parameter int                 DLY_W       = edtv_pkg::DLY_W_DEF,
    parameter int                 LINE_W      = edtv_pkg::LINE_W_DEF,
    parameter int                 PAT_LEN     = edtv_pkg::PAT_LEN_DEF,
    parameter int                 TARGET_LINE = edtv_pkg::TARGET_DEF,
    parameter logic [PAT_LEN-1:0] SIGNATURE   = edtv_pkg::SIGNATURE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nrz_clk,
    input  logic [LUMA_W-1:0] luma,
    input  logic [LUMA_W-1:0] sep_level,
    input  logic [DLY_W-1:0]  delay_cfg,
    input  logic              field_start,
    input  logic              line_start,
    output logic              edtv_id
);
    localparam int CNT_W = $clog2(PAT_LEN + 1);

    logic              edge_w;
    logic              strobe_w;
    logic [LINE_W-1:0] line_w;
    logic              target_w;
    logic              end_w;
    logic [CNT_W-1:0]  cnt_w;

    nrz_strobe_gen #(.DLY_W(DLY_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .nrz_clk  (nrz_clk),
        .delay_cfg(delay_cfg),
        .edge_o   (edge_w),
        .strobe_o (strobe_w)
    );

    line_tracker #(.LINE_W(LINE_W), .TARGET_LINE(TARGET_LINE)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_start(field_start),
        .line_start (line_start),
        .line_o     (line_w),
        .on_target_o(target_w),
        .end_o      (end_w)
    );

    pattern_sampler #(.LUMA_W(LUMA_W), .PAT_LEN(PAT_LEN), .SIGNATURE(SIGNATURE)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe_w),
        .on_target(target_w),
        .end_line (end_w),
        .luma     (luma),
        .sep_level(sep_level),
        .count_o  (cnt_w),
        .id_o     (edtv_id)
    );
endmodule

// File: rtl/edtv_detect_chk.sv
module edtv_detect_chk #(
    parameter int DLY_W   = 4,
    parameter int LINE_W  = 10,
    parameter int CNT_W   = 3,
    parameter int PAT_LEN = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              field_start,
    input logic [DLY_W-1:0]  delay_cfg,
    input logic              edtv_id,
    input logic              edge_w,
    input logic              strobe_w,
    input logic [LINE_W-1:0] line_w,
    input logic              end_w,
    input logic [CNT_W-1:0]  cnt_w
);
    // R8
    hold_between_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(end_w)) |-> $stable(edtv_id));

    // R5
    sample_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w <= CNT_W'(PAT_LEN));

    // R7
    full_before_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edtv_id) |-> ($past(cnt_w) == CNT_W'(PAT_LEN)));

    // R4
    field_resets_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (line_w == LINE_W'(1)));

    // R2
    zero_delay_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w && (delay_cfg == '0)) |-> strobe_w);
endmodule

bind edtv_detect edtv_detect_chk #(
    .DLY_W(DLY_W), .LINE_W(LINE_W), .CNT_W(CNT_W), .PAT_LEN(PAT_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_start(field_start),
    .delay_cfg  (delay_cfg),
    .edtv_id    (edtv_id),
    .edge_w     (edge_w),
    .strobe_w   (strobe_w),
    .line_w     (line_w),
    .end_w      (end_w),
    .cnt_w      (cnt_w)
);

// File: tb/test_edtv_detect.sv
`timescale 1ns/1ps
module test_edtv_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nrz_clk = 1'b0;
    logic [7:0] luma = '0;
    logic [7:0] sep_level = 8'd100;
    logic [3:0] delay_cfg = '0;
    logic       field_start = 1'b0;
    logic       line_start = 1'b0;
    logic       edtv_id;

    int  n_total = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    edtv_detect i_edtv_detect (
        .clk(clk), .rst_n(rst_n), .nrz_clk(nrz_clk), .luma(luma),
        .sep_level(sep_level), .delay_cfg(delay_cfg),
        .field_start(field_start), .line_start(line_start), .edtv_id(edtv_id)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // behavioural reference model
    int  m_line;
    bit  m_prev;
    int  due_at;
    int  cyc;
    bit  smp[$];
    bit  exp_id;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_line = 0; m_prev = 0; due_at = -1; cyc = 0; exp_id = 0;
            smp.delete();
        end else begin
            bit e, st, b, inl, endp;
            e = nrz_clk && !m_prev;
            m_prev = nrz_clk;
            st = (cyc == due_at) || (e && delay_cfg == 0);
            if (e) due_at = (delay_cfg == 0) ? -1 : cyc + int'(delay_cfg);
            b = (luma >= sep_level);
            inl = (m_line == 22);
            endp = inl && (line_start || field_start);
            if (endp) begin
                exp_id = (smp.size() == 5) && smp[0] && !smp[1] && smp[2] && smp[3] && !smp[4];
                smp.delete();
            end else if (st && inl && smp.size() < 5) begin
                smp.push_back(b);
            end
            if (field_start) m_line = 1;
            else if (line_start && m_line < 1023) m_line++;
            cyc++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) chk(edtv_id === exp_id, "R6 per-cycle model", int'(edtv_id), int'(exp_id));
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic run_field(input logic [4:0] bits, input int nedges, input int eline,
                             input int dly, input int hi, input int lo, input int last);
        delay_cfg = 4'(dly);
        field_start = 1'b1; tick(); field_start = 1'b0;
        for (int ln = 1; ln <= last; ln++) begin
            if (ln > 1) begin line_start = 1'b1; tick(); line_start = 1'b0; end
            if (ln == eline) begin
                for (int k = 0; k < nedges; k++) begin
                    luma = (k < 5 && bits[4-k]) ? 8'(hi) : 8'(lo);
                    nrz_clk = 1'b1; repeat (3) tick();
                    nrz_clk = 1'b0; repeat (3) tick();
                end
                repeat (12) tick();
            end else begin
                repeat (3) tick();
            end
        end
    endtask

    task automatic check_id(input bit expv, input string req);
        @(negedge clk);
        chk(edtv_id == expv, req, int'(edtv_id), int'(expv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(edtv_id == 1'b0, "R8 reset value", int'(edtv_id), 0);
        tick(); rst_n = 1'b1; tick();

        run_field(5'b10110, 5, 22, 2, 200, 20, 25); check_id(1'b1, "R6 signature match");
        run_field(5'b10111, 5, 22, 2, 200, 20, 25); check_id(1'b0, "R6 one bit wrong");
        run_field(5'b10110, 7, 22, 2, 200, 20, 25); check_id(1'b1, "R5 extra edges ignored");
        run_field(5'b10110, 4, 22, 2, 200, 20, 25); check_id(1'b0, "R7 four samples only");
        run_field(5'b10110, 5, 22, 0, 200, 20, 25); check_id(1'b1, "R2 zero delay");
        run_field(5'b10110, 5, 21, 2, 200, 20, 25); check_id(1'b0, "R4 code on line 21");
        run_field(5'b10110, 5, 22, 5, 200, 20, 25); check_id(1'b1, "R2 delay of five");
        run_field(5'b10110, 5, 22, 8, 200, 20, 25); check_id(1'b0, "R3 restart drops samples");
        run_field(5'b10110, 5, 22, 1, 100, 99, 25); check_id(1'b1, "R1 equal to threshold is one");
        run_field(5'b10110, 5, 22, 1, 99, 20, 25);  check_id(1'b0, "R1 below threshold is zero");
        run_field(5'b10110, 5, 22, 3, 200, 20, 22);
        field_start = 1'b1; tick(); field_start = 1'b0; tick();
        check_id(1'b1, "R6 field start ends target line");
        run_field(5'b00000, 0, 0, 3, 200, 20, 10); check_id(1'b1, "R8 holds before evaluation");
        run_field(5'b00000, 0, 0, 3, 200, 20, 25); check_id(1'b0, "R7 no samples");

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule